// File: doc/BRIEF.md
# In-System Serial Programming Target

This block is the device-side end of a serial programming link. While a session input is held high, an external programmer clocks 32-bit instruction frames into the block over a three-wire link (serial clock, data in, data out). The block decodes each frame and acts on an on-chip code store of 12288 bytes (addresses 0000h to 2FFFh). The code store is modelled as a register array. The block can unlock the interface, clear the whole store to FFh, program single bytes and return single bytes to the programmer.

The serial clock and data are brought into the system clock domain through two-flop synchronisers. Edges are detected there, so the serial clock must stay below one fortieth of the system clock. Byte programming is self-timed: the addressed byte is first set to FFh, and the new value is written when a programmable busy interval ends. While a programming or erase cycle runs, all newly arriving instructions are dropped.

Top module: `isp_target`

## Requirements
- R1: While `sess_en` is low, the frame bit position is held at zero and `miso` is low. A frame cut short by dropping `sess_en` leaves no trace, and the next frame after `sess_en` returns high is decoded from its first bit.
- R2: After `sess_en` rises, the store cannot be changed and reads return 00h until an unlock frame arrives. An unlock frame is opcode ACh followed by 53h; its last two bytes are ignored.
- R3: A frame is 32 bits sent MSB first and sampled on rising serial clock edges. Its bytes are, in order: opcode, address high, address low, data.
- R4: A write frame (opcode 40h) with an in-range address sets that byte to FFh, then stores the data byte after BUSY_CYCLES system clocks.
- R5: A chip-erase frame (opcode ACh, second byte 80h) sets every byte to FFh. It clears one 32-bit word per system clock, so the block is busy for ARRAY_BYTES/4 clocks.
- R6: A read frame (opcode 20h) returns the addressed byte on `miso` during the fourth byte, MSB first. `miso` changes after each falling serial clock edge and is low in the first three bytes.
- R7: Frames that complete while a write or erase cycle is running are ignored. A read whose address bytes complete during such a cycle returns 00h.
- R8: A write to an address of 3000h or above changes nothing, and a read of such an address returns 00h. Address 2FFFh is fully usable.
- R9: Dropping `sess_en` relocks the interface, and a new unlock frame is needed in the next session.
- R10: Frames with any other opcode have no effect on the store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sess_en | input | 1 | Programming session active while high (asynchronous, synchronised inside) |
| sck | input | 1 | Serial clock from the programmer (asynchronous) |
| mosi | input | 1 | Serial data into the block (asynchronous) |
| miso | output | 1 | Serial data out to the programmer |

## Verification
Write-then-read pairs at random in-range addresses with random data show that bytes land at the right address and come back in the right bit order. Directed patterns cover the cases that random traffic would seldom hit: a read issued right after a write (busy, so 00h), a second write while the first is still running, a write just after a chip erase, the last valid address against the first invalid one, and an unknown opcode. Session drops, both between frames and in the middle of one, show that the lock and the bit alignment both restart.

// File: rtl/isp_pkg.sv
package isp_pkg;

    localparam int FRAME_BITS = 32;

    localparam logic [7:0] OP_SPECIAL = 8'hAC;
    localparam logic [7:0] SUB_UNLOCK = 8'h53;
    localparam logic [7:0] SUB_ERASE  = 8'h80;
    localparam logic [7:0] OP_WRITE   = 8'h40;
    localparam logic [7:0] OP_READ    = 8'h20;

    typedef struct packed {
        logic [7:0] op;
        logic [7:0] ahi;
        logic [7:0] alo;
        logic [7:0] dat;
    } frame_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BYTE,
        ST_CHIP
    } state_t;

    function automatic logic addr_ok(input logic [15:0] a, input int unsigned lim);
        return 32'(a) < lim;
    endfunction

endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= d[g];
                stab_q <= meta_q;
            end
        end
        assign q[g] = stab_q;
    end
endmodule

// File: rtl/isp_shifter.sv
module isp_shifter
    import isp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       sck_s,
    input  logic       mosi_s,
    input  logic [7:0] tx_byte,
    output logic       hdr_rdy,
    output logic       frame_rdy,
    output frame_t     frm,
    output logic       miso
);
    localparam int CNT_W   = $clog2(FRAME_BITS);
    localparam int HDR_BIT = FRAME_BITS - 8;

    logic             sck_d;
    logic [CNT_W-1:0] cnt_q;
    logic [FRAME_BITS-1:0] sh_q;
    logic [7:0]       tx_q;
    logic             rise, fall;

    assign rise = sck_s & ~sck_d;
    assign fall = ~sck_s & sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d     <= 1'b0;
            cnt_q     <= '0;
            sh_q      <= '0;
            tx_q      <= '0;
            hdr_rdy   <= 1'b0;
            frame_rdy <= 1'b0;
        end else if (!active) begin
            sck_d     <= sck_s;
            cnt_q     <= '0;
            sh_q      <= '0;
            tx_q      <= '0;
            hdr_rdy   <= 1'b0;
            frame_rdy <= 1'b0;
        end else begin
            sck_d     <= sck_s;
            hdr_rdy   <= 1'b0;
            frame_rdy <= 1'b0;
            if (rise) begin
                sh_q  <= {sh_q[FRAME_BITS-2:0], mosi_s};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(HDR_BIT - 1))    hdr_rdy   <= 1'b1;
                if (cnt_q == CNT_W'(FRAME_BITS - 1)) begin
                    frame_rdy <= 1'b1;
                    tx_q      <= '0;
                end
            end else if (fall) begin
                if (cnt_q == CNT_W'(HDR_BIT))     tx_q <= tx_byte;
                else if (cnt_q > CNT_W'(HDR_BIT)) tx_q <= {tx_q[6:0], 1'b0};
            end
        end
    end

    assign frm  = frame_t'(sh_q);
    assign miso = (cnt_q >= CNT_W'(HDR_BIT)) ? tx_q[7] : 1'b0;

    AST_QUIET_OFF_SESSION: assert property (@(posedge clk) disable iff (rst)
        !active |=> !miso); // R1
    AST_PULSE_APART: assert property (@(posedge clk) disable iff (rst)
        !(hdr_rdy && frame_rdy)); // R3
endmodule

// File: rtl/isp_array.sv
module isp_array #(
    parameter int BYTES = 12288,
    localparam int BW    = $clog2(BYTES),
    localparam int AW    = BW - 2,
    localparam int WORDS = BYTES / 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [BW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          clr,
    input  logic [AW-1:0] cidx,
    input  logic [BW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] lane_q [4];
    logic [1:0] sel_q;

    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] mem [WORDS];
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (clr)
                mem[cidx] <= 8'hFF;
            else if (we && waddr[1:0] == 2'(g))
                mem[waddr[BW-1:2]] <= wdata;
            q <= mem[raddr[BW-1:2]];
        end
        assign lane_q[g] = q;
    end

    always_ff @(posedge clk) sel_q <= raddr[1:0];

    assign rdata = lane_q[sel_q];

    AST_WRITE_IN_RANGE: assert property (@(posedge clk)
        we |-> (32'(waddr) < BYTES)); // R8
    AST_ERASE_IN_RANGE: assert property (@(posedge clk)
        clr |-> (32'(cidx) < WORDS)); // R5
endmodule

// File: rtl/isp_ctrl.sv
module isp_ctrl
    import isp_pkg::*;
#(
    parameter int BYTES       = 12288,
    parameter int BUSY_CYCLES = 1500,
    localparam int BW    = $clog2(BYTES),
    localparam int AW    = BW - 2,
    localparam int WORDS = BYTES / 4,
    localparam int CW    = $clog2(BUSY_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          hdr_rdy,
    input  logic          frame_rdy,
    input  frame_t        frm,
    output logic          mem_we,
    output logic [BW-1:0] mem_waddr,
    output logic [7:0]    mem_wdata,
    output logic          mem_clr,
    output logic [AW-1:0] mem_cidx,
    output logic [BW-1:0] rd_addr,
    output logic          rd_ok
);
    state_t        st_q;
    logic          unlocked_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] cidx_q;
    logic [BW-1:0] addr_q;
    logic [7:0]    dat_q;

    // At the header pulse only 24 bits have arrived, so the opcode sits in
    // the second field of the shift register and the address in the last two.
    logic [7:0]  hdr_op;
    logic [15:0] hdr_addr;
    logic [15:0] frm_addr;
    logic        idle, can_start;

    assign hdr_op    = frm.ahi;
    assign hdr_addr  = {frm.alo, frm.dat};
    assign frm_addr  = {frm.ahi, frm.alo};
    assign idle      = (st_q == ST_IDLE);
    assign can_start = frame_rdy && unlocked_q && idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            unlocked_q <= 1'b0;
            cnt_q      <= '0;
            cidx_q     <= '0;
            addr_q     <= '0;
            dat_q      <= '0;
            rd_addr    <= '0;
            rd_ok      <= 1'b0;
        end else begin
            case (st_q)
                ST_BYTE: begin
                    if (cnt_q == CW'(BUSY_CYCLES - 1)) st_q <= ST_IDLE;
                    cnt_q <= cnt_q + 1'b1;
                end
                ST_CHIP: begin
                    if (cidx_q == AW'(WORDS - 1)) st_q <= ST_IDLE;
                    cidx_q <= cidx_q + 1'b1;
                end
                default: begin
                    if (can_start && frm.op == OP_WRITE && addr_ok(frm_addr, BYTES)) begin
                        st_q   <= ST_BYTE;
                        cnt_q  <= '0;
                        addr_q <= BW'(frm_addr);
                        dat_q  <= frm.dat;
                    end else if (can_start && frm.op == OP_SPECIAL && frm.ahi == SUB_ERASE) begin
                        st_q   <= ST_CHIP;
                        cidx_q <= '0;
                    end
                end
            endcase

            if (hdr_rdy) begin
                rd_addr <= BW'(hdr_addr);
                rd_ok   <= unlocked_q && idle && hdr_op == OP_READ
                           && addr_ok(hdr_addr, BYTES);
            end

            if (frame_rdy && frm.op == OP_SPECIAL && frm.ahi == SUB_UNLOCK)
                unlocked_q <= 1'b1;

            if (!active) begin
                unlocked_q <= 1'b0;
                rd_ok      <= 1'b0;
            end
        end
    end

    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = addr_q;
        mem_wdata = 8'hFF;
        mem_clr   = (st_q == ST_CHIP);
        mem_cidx  = cidx_q;
        if (st_q == ST_BYTE) begin
            if (cnt_q == '0) begin
                mem_we = 1'b1;
            end else if (cnt_q == CW'(BUSY_CYCLES - 1)) begin
                mem_we    = 1'b1;
                mem_wdata = dat_q;
            end
        end
    end

    AST_NO_START_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (idle && !unlocked_q) |=> (st_q == ST_IDLE)); // R2
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BYTE) |-> (cnt_q < CW'(BUSY_CYCLES))); // R4
    AST_ONE_MEM_OP: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, mem_clr})); // R5
    AST_SESSION_RELOCK: assert property (@(posedge clk) disable iff (rst)
        !active |=> !unlocked_q); // R9
    AST_BUSY_STAYS: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BYTE && cnt_q != CW'(BUSY_CYCLES - 1)) |=> (st_q == ST_BYTE)); // R7
endmodule

// File: rtl/isp_target.sv
module isp_target
    import isp_pkg::*;
#(
    parameter int ARRAY_BYTES = 12288,
    parameter int BUSY_CYCLES = 1500,
    localparam int BW = $clog2(ARRAY_BYTES),
    localparam int AW = BW - 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sess_en,
    input  logic sck,
    input  logic mosi,
    output logic miso
);
    logic [2:0]    sync_q;
    logic          active, sck_s, mosi_s;
    logic          hdr_rdy, frame_rdy;
    frame_t        frm;
    logic          mem_we, mem_clr, rd_ok;
    logic [BW-1:0] mem_waddr, rd_addr;
    logic [7:0]    mem_wdata, rd_data, tx_byte;
    logic [AW-1:0] mem_cidx;

    isp_sync #(.W(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sess_en, sck, mosi}),
        .q   (sync_q)
    );
    assign {active, sck_s, mosi_s} = sync_q;

    isp_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .sck_s     (sck_s),
        .mosi_s    (mosi_s),
        .tx_byte   (tx_byte),
        .hdr_rdy   (hdr_rdy),
        .frame_rdy (frame_rdy),
        .frm       (frm),
        .miso      (miso)
    );

    isp_ctrl #(.BYTES(ARRAY_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .hdr_rdy   (hdr_rdy),
        .frame_rdy (frame_rdy),
        .frm       (frm),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_clr   (mem_clr),
        .mem_cidx  (mem_cidx),
        .rd_addr   (rd_addr),
        .rd_ok     (rd_ok)
    );

    isp_array #(.BYTES(ARRAY_BYTES)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .clr   (mem_clr),
        .cidx  (mem_cidx),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign tx_byte = rd_ok ? rd_data : 8'h00;
endmodule

// File: tb/isp_target_tb.sv
module isp_target_tb;
    localparam int BYTES = 12288;
    localparam int BUSY  = 1500;
    localparam int HALF  = 20;

    logic clk = 1'b0, rst = 1'b1, sess_en = 1'b0, sck = 1'b0, mosi = 1'b0;
    logic miso;
    int   n_chk = 0, n_fail = 0;
    logic [7:0] refm [int];

    isp_target #(.ARRAY_BYTES(BYTES), .BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst(rst), .sess_en(sess_en), .sck(sck), .mosi(mosi), .miso(miso));

    always #5 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int a);
        if (a >= BYTES) return 8'h00;
        if (refm.exists(a)) return refm[a];
        return 8'hFF;
    endfunction

    task automatic xfer(input logic [7:0] b0, b1, b2, b3, input int nbits, output logic [7:0] rx);
        logic [31:0] w;
        w  = {b0, b1, b2, b3};
        rx = 8'h00;
        for (int i = 31; i > 31 - nbits; i--) begin
            sck  = 1'b0;
            mosi = w[i];
            tick(HALF);
            if (i < 8) rx = {rx[6:0], miso};
            sck = 1'b1;
            tick(HALF);
        end
        sck = 1'b0;
        tick(4);
    endtask

    task automatic frame(input logic [7:0] b0, b1, b2, b3);
        logic [7:0] rx;
        xfer(b0, b1, b2, b3, 32, rx);
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        xfer(8'h20, 8'(a >> 8), 8'(a), 8'h00, 32, v);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        frame(8'h40, 8'(a >> 8), 8'(a), d);
    endtask

    task automatic unlock();
        frame(8'hAC, 8'h53, 8'h00, 8'h00);
    endtask

    task automatic erase_all();
        frame(8'hAC, 8'h80, 8'h00, 8'h00);
        refm.delete();
    endtask

    task automatic new_session();
        sess_en = 1'b0;
        tick(10);
        sess_en = 1'b1;
        tick(10);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        tick(195000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        int a, a2, seed;
        logic [7:0] d;
        seed = int'($urandom(32'd2024));
        tick(5);
        rst = 1'b0;
        tick(5);
        check(miso == 1'b0, "R1 reset miso", {7'b0, miso}, 8'h00);

        sess_en = 1'b1;
        tick(10);
        unlock();
        erase_all();
        tick(3300);
        rd(16'h0000, v); check(v == 8'hFF, "R5 erase low", v, 8'hFF);
        rd(16'h2FFF, v); check(v == 8'hFF, "R5 erase top", v, 8'hFF);

        // R2 / R9: a new session is locked again
        new_session();
        wr(16'h0010, 8'h5A);
        tick(BUSY + 100);
        rd(16'h0010, v); check(v == 8'h00, "R2 locked read", v, 8'h00);
        unlock();
        rd(16'h0010, v); check(v == 8'hFF, "R9 locked write ignored", v, 8'hFF);

        // R4 / R7: read while byte cycle runs, then after
        wr(16'h0123, 8'hA5);
        rd(16'h0123, v); check(v == 8'h00, "R7 read while busy", v, 8'h00);
        tick(BUSY + 100);
        refm[16'h0123] = 8'hA5;
        rd(16'h0123, v); check(v == 8'hA5, "R4 write A5", v, 8'hA5);

        // R3 / R6: random write/read pairs
        for (int k = 0; k < 12; k++) begin
            a = int'($urandom % BYTES);
            d = 8'($urandom);
            wr(a, d);
            refm[a] = d;
            tick(BUSY + 100);
            rd(a, v);
            check(v == exp_byte(a), "R3 R6 random readback", v, exp_byte(a));
        end

        // R8: boundary
        wr(16'h2FFF, 8'h3C);
        tick(BUSY + 100);
        refm[16'h2FFF] = 8'h3C;
        rd(16'h2FFF, v); check(v == 8'h3C, "R8 last address", v, 8'h3C);
        wr(16'h3000, 8'h11);
        tick(BUSY + 100);
        rd(16'h3000, v); check(v == 8'h00, "R8 out of range read", v, 8'h00);
        rd(16'h0000, v); check(v == exp_byte(0), "R8 no wrap to 0", v, exp_byte(0));

        // R7: second write while first still busy
        a  = 16'h0200;
        a2 = 16'h0201;
        wr(a, 8'h81);
        wr(a2, 8'h7E);
        tick(BUSY + 100);
        refm[a] = 8'h81;
        rd(a2, v); check(v == exp_byte(a2), "R7 write while busy ignored", v, exp_byte(a2));
        rd(a, v);  check(v == 8'h81, "R7 first write kept", v, 8'h81);

        // R10: unknown opcode
        frame(8'h60, 8'h02, 8'h00, 8'h00);
        tick(BUSY + 100);
        rd(a, v); check(v == 8'h81, "R10 unknown opcode", v, 8'h81);

        // R5 / R7: write just after chip erase is dropped
        erase_all();
        wr(16'h0444, 8'h12);
        tick(3300);
        rd(16'h0444, v); check(v == 8'hFF, "R7 write during erase", v, 8'hFF);
        rd(16'h0123, v); check(v == 8'hFF, "R5 erase clears written", v, 8'hFF);

        // R1: session dropped mid-frame
        wr(16'h0055, 8'hC3);
        tick(BUSY + 100);
        refm[16'h0055] = 8'hC3;
        begin
            logic [7:0] junk;
            xfer(8'h40, 8'h00, 8'h55, 8'h00, 13, junk);
        end
        new_session();
        unlock();
        rd(16'h0055, v); check(v == 8'hC3, "R1 realign after drop", v, 8'hC3);
        sess_en = 1'b0;
        tick(6);
        check(miso == 1'b0, "R1 miso low off session", {7'b0, miso}, 8'h00);

        summary();
        $finish;
    end
endmodule